// File: doc/BRIEF.md
# Run-Length Infrared Transmitter with Carrier Modulation

This block turns a stream of durations into an infrared drive waveform. Each accepted duration is one sample, counted in sample periods. The first sample after a start is a mark (emitter active) and the polarity flips with every new sample. A mark is gated by a carrier whose period and high time are counted in 500 ns units. A space is always dark.

A chunker cuts each duration into chunks of at most 127 sample periods. Every chunk carries a polarity flag. Chunks go into two holding slots, which are filled and drained in strict alternation. The output engine plays one slot while the other is refilled. Each time a slot drains, the engine raises a one-cycle interrupt. After the final chunk has been played out, one more interrupt marks completion, and the transmitter drops back to idle.

The carrier has two settings, period and duty percentage. They are loaded together, and the high time is derived from them as the sample is configured. A 2-bit emitter mask chooses which of the two emitter outputs carry the waveform. A mask that would be empty, or that would name an emitter that does not exist, is refused.

Top module: `ir_rl_tx`

## Requirements
- R1: After reset the block is idle (`tx_busy`=0, `ir_out`=0, `smp_ready`=0), `emit_en`=2'b11, and the carrier uses a period of 32 units at 50 percent duty, which gives a high time of 16 units.
- R2: The carrier high time is period / (100 / duty), with a minimum of 1. A duty of 0 counts as 1 and a duty above 99 counts as 99. A period of 0 turns modulation off, so a mark drives the output steadily high. The carrier phase restarts at the start of every mark.
- R3: The first sample after start is a mark and each later sample takes the opposite polarity. A sample of N periods holds its level for exactly N*SAMPLE_TICKS clock cycles, and consecutive samples follow with no gap.
- R4: A duration above 127 is sent as chunks of 127 followed by the remainder, all of the same polarity and played back to back.
- R5: A duration of 0 is sent as one sample period.
- R6: After start, output does not begin until both slots hold a chunk, or until the final sample has been fully queued.
- R7: `slot_irq` pulses for one cycle each time a slot drains, so there is exactly one pulse per chunk.
- R8: `tx_done` pulses together with the interrupt of the final chunk, and `tx_busy` falls on the next cycle. While idle, `ir_out` is 0.
- R9: A mask load with value 0, or with bit 2 or bit 3 set (`mask_in` is 4 bits), is refused. A refusal pulses `mask_err` and leaves `emit_en` unchanged. Any other value takes bits [1:0] as the new `emit_en`. `ir_out[i]` can only be high while `emit_en[i]` is 1.
- R10: `ir_out` is 0 during spaces.
- R11: `smp_ready` is high only while busy. A `start` that arrives while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transmission (ignored while busy) |
| cfg_load | input | 1 | Load carrier period and duty |
| cfg_period | input | 7 | Carrier period in 500 ns units, 0 = no modulation |
| cfg_duty | input | 7 | Carrier duty in percent |
| mask_load | input | 1 | Request a new emitter mask |
| mask_in | input | 4 | Requested emitter mask |
| smp_valid | input | 1 | Sample offered |
| smp_ready | output | 1 | Sample accepted this cycle when valid |
| smp_dur | input | DUR_W | Sample duration in sample periods |
| smp_last | input | 1 | Marks the final sample |
| emit_en | output | 2 | Active emitter enables |
| ir_out | output | 2 | Modulated drive for each emitter |
| slot_irq | output | 1 | One-cycle pulse when a slot drains |
| tx_busy | output | 1 | Transmission in progress |
| tx_done | output | 1 | Final chunk has left the output |
| mask_err | output | 1 | One-cycle pulse on a refused mask |

## Verification
The bench measures the length of each mark and space in cycles, so it finds any error of one sample in the split of a long duration, and any lost chunk or gap at a slot hand-over. A zero-length sample must show up as one full period: a design that passed it through as zero would drop the mark and merge the two spaces around it. The bench also holds back the second sample after start. An engine that began without preloading would then light the emitter early. The bench counts carrier high cycles at several duty settings, so it finds a wrong high-time rounding and a missing minimum of 1. It also tries refused masks and a second start during a transmission, and checks that neither changes the outputs.

// File: rtl/irtx_pkg.sv
package irtx_pkg;

    localparam int CNT_W = 7;
    localparam int PRD_W = 7;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             mark;
        logic [CNT_W-1:0] count;
    } chunk_t;

    typedef struct packed {
        logic   full;
        chunk_t data;
    } slot_t;

    function automatic logic [PRD_W-1:0] hi_width(input logic [PRD_W-1:0] prd,
                                                   input logic [6:0] duty);
        logic [6:0]       d;
        logic [6:0]       q;
        logic [PRD_W-1:0] h;
        if (duty == 7'd0)
            d = 7'd1;
        else if (duty > 7'd99)
            d = 7'd99;
        else
            d = duty;
        q = 7'd100 / d;
        h = prd / q;
        if (h == '0)
            h = PRD_W'(1);
        return h;
    endfunction

endpackage

// File: rtl/irtx_carrier.sv
module irtx_carrier
    import irtx_pkg::*;
#(
    parameter int HALF_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [PRD_W-1:0] period,
    input  logic [PRD_W-1:0] high,
    output logic             car
);
    localparam int PW = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(HALF_TICKS - 1);

    logic [PW-1:0]    pre_q;
    logic [PRD_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            pre_q   <= '0;
            phase_q <= '0;
        end else if (pre_q == PRE_LAST) begin
            pre_q <= '0;
            if (period == '0 || phase_q == period - PRD_W'(1))
                phase_q <= '0;
            else
                phase_q <= phase_q + PRD_W'(1);
        end else begin
            pre_q <= pre_q + PW'(1);
        end
    end

    assign car = (period == '0) || (phase_q < high);

endmodule

// File: rtl/irtx_chunker.sv
module irtx_chunker
    import irtx_pkg::*;
#(
    parameter int DUR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             busy,
    input  logic             smp_valid,
    input  logic [DUR_W-1:0] smp_dur,
    input  logic             smp_last,
    output logic             smp_ready,
    input  logic             wr_full,
    output logic             wr_req,
    output chunk_t           wr_data,
    output logic             drained
);
    localparam logic [DUR_W-1:0] MAX_D = DUR_W'(CNT_MAX);

    logic             have_q;
    logic             mark_q;
    logic             last_q;
    logic             fin_q;
    logic [DUR_W-1:0] rem_q;
    logic [DUR_W-1:0] take;

    assign take      = (rem_q > MAX_D) ? MAX_D : rem_q;
    assign smp_ready = busy && !have_q && !fin_q;
    assign wr_req    = have_q && !wr_full;
    assign wr_data   = '{mark: mark_q, count: CNT_W'(take)};
    assign drained   = fin_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            have_q <= 1'b0;
            mark_q <= 1'b0;
            last_q <= 1'b0;
            fin_q  <= 1'b0;
            rem_q  <= '0;
        end else if (smp_ready && smp_valid) begin
            have_q <= 1'b1;
            mark_q <= ~mark_q;
            last_q <= smp_last;
            rem_q  <= (smp_dur == '0) ? DUR_W'(1) : smp_dur;
        end else if (wr_req) begin
            rem_q <= rem_q - take;
            if (rem_q == take) begin
                have_q <= 1'b0;
                fin_q  <= last_q;
            end
        end
    end

endmodule

// File: rtl/irtx_slots.sv
module irtx_slots
    import irtx_pkg::*;
#(
    parameter int SAMPLE_TICKS = 100
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   clear,
    input  logic   busy,
    input  logic   wr_req,
    input  chunk_t wr_data,
    input  logic   drained,
    output logic   wr_full,
    output logic   env,
    output logic   irq,
    output logic   done
);
    localparam int SW = (SAMPLE_TICKS > 1) ? $clog2(SAMPLE_TICKS) : 1;
    localparam logic [SW-1:0] SUB_LAST = SW'(SAMPLE_TICKS - 1);

    slot_t            slot_q [2];
    logic             wr_sel_q;
    logic             rd_sel_q;
    logic             active_q;
    logic             begun_q;
    logic [SW-1:0]    sub_q;
    logic [CNT_W-1:0] left_q;
    logic             chunk_end;
    logic             can_begin;
    slot_t            cur;
    slot_t            nxt;

    assign cur       = slot_q[rd_sel_q];
    assign nxt       = slot_q[~rd_sel_q];
    assign wr_full   = slot_q[wr_sel_q].full;
    assign chunk_end = active_q && (sub_q == SUB_LAST) && (left_q == CNT_W'(1));
    assign can_begin = busy && cur.full && (begun_q || nxt.full || drained);
    assign env       = active_q && cur.data.mark;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            for (int i = 0; i < 2; i++)
                slot_q[i] <= '0;
            wr_sel_q <= 1'b0;
            rd_sel_q <= 1'b0;
            active_q <= 1'b0;
            begun_q  <= 1'b0;
            sub_q    <= '0;
            left_q   <= '0;
            irq      <= 1'b0;
            done     <= 1'b0;
        end else begin
            irq  <= 1'b0;
            done <= 1'b0;
            if (wr_req) begin
                slot_q[wr_sel_q] <= '{full: 1'b1, data: wr_data};
                wr_sel_q         <= ~wr_sel_q;
            end
            if (!active_q) begin
                if (can_begin) begin
                    active_q <= 1'b1;
                    begun_q  <= 1'b1;
                    sub_q    <= '0;
                    left_q   <= cur.data.count;
                end
            end else if (sub_q != SUB_LAST) begin
                sub_q <= sub_q + SW'(1);
            end else begin
                sub_q <= '0;
                if (!chunk_end) begin
                    left_q <= left_q - CNT_W'(1);
                end else begin
                    slot_q[rd_sel_q].full <= 1'b0;
                    rd_sel_q <= ~rd_sel_q;
                    irq      <= 1'b1;
                    if (nxt.full) begin
                        left_q <= nxt.data.count;
                    end else begin
                        active_q <= 1'b0;
                        done     <= drained;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/ir_rl_tx.sv
module ir_rl_tx
    import irtx_pkg::*;
#(
    parameter int DUR_W        = 16,
    parameter int SAMPLE_TICKS = 100,
    parameter int HALF_TICKS   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             cfg_load,
    input  logic [6:0]       cfg_period,
    input  logic [6:0]       cfg_duty,
    input  logic             mask_load,
    input  logic [3:0]       mask_in,
    input  logic             smp_valid,
    output logic             smp_ready,
    input  logic [DUR_W-1:0] smp_dur,
    input  logic             smp_last,
    output logic [1:0]       emit_en,
    output logic [1:0]       ir_out,
    output logic             slot_irq,
    output logic             tx_busy,
    output logic             tx_done,
    output logic             mask_err
);
    localparam logic [PRD_W-1:0] RST_PRD  = PRD_W'(32);
    localparam logic [6:0]       RST_DUTY = 7'd50;

    logic             busy_q;
    logic             go;
    logic [PRD_W-1:0] prd_q;
    logic [PRD_W-1:0] high_q;
    logic [1:0]       mask_q;
    logic             err_q;
    logic             mask_ok;
    logic             wr_full;
    logic             wr_req;
    chunk_t           wr_data;
    logic             drained;
    logic             env;
    logic             car;
    logic             irq;
    logic             done;

    assign go      = start && !busy_q;
    assign mask_ok = (mask_in[1:0] != 2'b00) && (mask_in[3:2] == 2'b00);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            prd_q  <= RST_PRD;
            high_q <= hi_width(RST_PRD, RST_DUTY);
            mask_q <= 2'b11;
            err_q  <= 1'b0;
        end else begin
            if (go)
                busy_q <= 1'b1;
            else if (done)
                busy_q <= 1'b0;
            if (cfg_load) begin
                prd_q  <= cfg_period;
                high_q <= hi_width(cfg_period, cfg_duty);
            end
            err_q <= mask_load && !mask_ok;
            if (mask_load && mask_ok)
                mask_q <= mask_in[1:0];
        end
    end

    irtx_chunker #(.DUR_W(DUR_W)) u_chunk (
        .clk       (clk),
        .rst       (rst),
        .clear     (go),
        .busy      (busy_q),
        .smp_valid (smp_valid),
        .smp_dur   (smp_dur),
        .smp_last  (smp_last),
        .smp_ready (smp_ready),
        .wr_full   (wr_full),
        .wr_req    (wr_req),
        .wr_data   (wr_data),
        .drained   (drained)
    );

    irtx_slots #(.SAMPLE_TICKS(SAMPLE_TICKS)) u_slots (
        .clk     (clk),
        .rst     (rst),
        .clear   (go),
        .busy    (busy_q),
        .wr_req  (wr_req),
        .wr_data (wr_data),
        .drained (drained),
        .wr_full (wr_full),
        .env     (env),
        .irq     (irq),
        .done    (done)
    );

    irtx_carrier #(.HALF_TICKS(HALF_TICKS)) u_car (
        .clk    (clk),
        .rst    (rst),
        .en     (env),
        .period (prd_q),
        .high   (high_q),
        .car    (car)
    );

    assign ir_out   = {2{env && car}} & mask_q;
    assign emit_en  = mask_q;
    assign slot_irq = irq;
    assign tx_busy  = busy_q;
    assign tx_done  = done;
    assign mask_err = err_q;

endmodule

// File: rtl/ir_rl_tx_chk.sv
module ir_rl_tx_chk (
    input logic       clk,
    input logic       rst,
    input logic       mask_load,
    input logic [3:0] mask_in,
    input logic [1:0] emit_en,
    input logic [1:0] ir_out,
    input logic       slot_irq,
    input logic       tx_busy,
    input logic       tx_done,
    input logic       smp_ready,
    input logic       mask_err
);
    a_r8_idle_dark: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> ir_out == 2'b00);

    a_r8_done_with_irq: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> slot_irq);

    a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
        tx_done |=> !tx_busy);

    a_r7_irq_in_busy: assert property (@(posedge clk) disable iff (rst)
        slot_irq |-> tx_busy);

    a_r11_ready_in_busy: assert property (@(posedge clk) disable iff (rst)
        smp_ready |-> tx_busy);

    a_r9_refused_mask: assert property (@(posedge clk) disable iff (rst)
        (mask_load && (mask_in[1:0] == 2'b00 || mask_in[3:2] != 2'b00))
            |=> (mask_err && $stable(emit_en)));

    a_r9_mask_never_empty: assert property (@(posedge clk) disable iff (rst)
        $countones(emit_en) >= 1);

    a_r9_out_within_mask: assert property (@(posedge clk) disable iff (rst)
        (ir_out & ~emit_en) == 2'b00);

endmodule

bind ir_rl_tx ir_rl_tx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mask_load (mask_load),
    .mask_in   (mask_in),
    .emit_en   (emit_en),
    .ir_out    (ir_out),
    .slot_irq  (slot_irq),
    .tx_busy   (tx_busy),
    .tx_done   (tx_done),
    .smp_ready (smp_ready),
    .mask_err  (mask_err)
);

// File: tb/ir_rl_tx_tb.sv
module ir_rl_tx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW  = 16;
    localparam int TS  = 3;
    localparam int TH  = 1;

    logic          clk = 1'b0;
    logic          rst;
    logic          start, cfg_load, mask_load, smp_valid, smp_last;
    logic [6:0]    cfg_period, cfg_duty;
    logic [3:0]    mask_in;
    logic [DW-1:0] smp_dur;
    logic          smp_ready, slot_irq, tx_busy, tx_done, mask_err;
    logic [1:0]    emit_en, ir_out;

    int n_chk = 0;
    int n_bad = 0;

    int seq[8];
    int seq_n;
    int highs[8];
    int lows[8];
    int nh, nl, run_len, irqs, hc0, hc1;
    logic prev;

    always #(CLK_PERIOD/2) clk = ~clk;

    ir_rl_tx #(.DUR_W(DW), .SAMPLE_TICKS(TS), .HALF_TICKS(TH)) u_dut (
        .clk(clk), .rst(rst), .start(start), .cfg_load(cfg_load),
        .cfg_period(cfg_period), .cfg_duty(cfg_duty), .mask_load(mask_load),
        .mask_in(mask_in), .smp_valid(smp_valid), .smp_ready(smp_ready),
        .smp_dur(smp_dur), .smp_last(smp_last), .emit_en(emit_en),
        .ir_out(ir_out), .slot_irq(slot_irq), .tx_busy(tx_busy),
        .tx_done(tx_done), .mask_err(mask_err)
    );

    always @(negedge clk) begin
        if (slot_irq) irqs++;
        if (ir_out[0]) hc0++;
        if (ir_out[1]) hc1++;
        if (ir_out[0] != prev) begin
            if (prev) begin
                if (nh < 8) highs[nh] = run_len;
                nh++;
            end else if (nh > 0) begin
                if (nl < 8) lows[nl] = run_len;
                nl++;
            end
            run_len = 1;
        end else begin
            run_len++;
        end
        prev = ir_out[0];
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clr_rec();
        nh = 0; nl = 0; run_len = 0; irqs = 0; hc0 = 0; hc1 = 0;
        prev = 1'b0;
        for (int i = 0; i < 8; i++) begin
            highs[i] = 0;
            lows[i] = 0;
        end
    endtask

    task automatic push(input int d, input logic last);
        smp_valid = 1'b1;
        smp_dur   = DW'(d);
        smp_last  = last;
        while (!smp_ready) @(negedge clk);
        @(negedge clk);
        smp_valid = 1'b0;
        smp_last  = 1'b0;
    endtask

    task automatic begin_tx();
        clr_rec();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!tx_done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(req, int'(tx_done), 1);
        @(negedge clk);
        check(req, int'(tx_busy), 0);
        repeat (3) @(negedge clk);
        check(req, int'(ir_out), 0);
    endtask

    task automatic send_seq(input string req);
        begin_tx();
        for (int i = 0; i < seq_n; i++)
            push(seq[i], i == seq_n - 1);
        wait_done(req);
    endtask

    task automatic set_cfg(input int p, input int d);
        cfg_period = 7'(p);
        cfg_duty   = 7'(d);
        cfg_load   = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic t_reset();
        smp_valid = 1'b1;
        @(negedge clk);
        check("R1 busy", int'(tx_busy), 0);
        check("R1 ir_out", int'(ir_out), 0);
        check("R1 emit_en", int'(emit_en), 3);
        check("R11 ready idle", int'(smp_ready), 0);
        smp_valid = 1'b0;
    endtask

    task automatic t_default_carrier();
        seq[0] = 64; seq_n = 1;
        send_seq("R1 default tx");
        check("R1 default carrier high cycles", hc0, 96);
        check("R7 irq count", irqs, 1);
    endtask

    task automatic t_basic();
        set_cfg(0, 50);
        seq[0] = 5; seq[1] = 2; seq[2] = 7; seq_n = 3;
        send_seq("R8 basic");
        check("R3 marks", nh, 2);
        check("R3 mark0", highs[0], 15);
        check("R10 space", lows[0], 6);
        check("R3 mark1", highs[1], 21);
        check("R7 irqs", irqs, 3);
    endtask

    task automatic t_split();
        seq[0] = 300; seq[1] = 10; seq[2] = 0; seq_n = 3;
        send_seq("R4 split");
        check("R4 long mark", highs[0], 900);
        check("R4 space", lows[0], 30);
        check("R5 zero mark", highs[1], 3);
        check("R7 irqs split", irqs, 5);
    endtask

    task automatic t_space_split();
        seq[0] = 1; seq[1] = 254; seq[2] = 1; seq_n = 3;
        send_seq("R4 space split");
        check("R4 long space", lows[0], 762);
        check("R4 marks", nh, 2);
        check("R7 irqs space", irqs, 4);
        seq[0] = 0; seq[1] = 4; seq[2] = 2; seq_n = 3;
        send_seq("R5 zero first");
        check("R5 zero first mark", highs[0], 3);
        check("R5 space", lows[0], 12);
        check("R5 mark", highs[1], 6);
    endtask

    task automatic t_preload();
        begin_tx();
        push(6, 1'b0);
        repeat (20) @(negedge clk);
        check("R6 no early output", hc0, 0);
        check("R6 still busy", int'(tx_busy), 1);
        push(6, 1'b1);
        wait_done("R6 done");
        check("R6 mark", highs[0], 18);
        check("R6 one mark", nh, 1);
    endtask

    task automatic t_carrier();
        seq[0] = 40; seq_n = 1;
        set_cfg(4, 50);
        send_seq("R2 c50");
        check("R2 duty50", hc0, 60);
        set_cfg(4, 30);
        send_seq("R2 c30");
        check("R2 duty30", hc0, 30);
        set_cfg(4, 1);
        send_seq("R2 c1");
        check("R2 min width", hc0, 30);
        set_cfg(0, 50);
        send_seq("R2 c0");
        check("R2 no modulation", hc0, 120);
    endtask

    task automatic t_mask();
        mask_in = 4'b0000; mask_load = 1'b1;
        @(negedge clk);
        mask_load = 1'b0;
        check("R9 err zero", int'(mask_err), 1);
        check("R9 kept", int'(emit_en), 3);
        mask_in = 4'b0110; mask_load = 1'b1;
        @(negedge clk);
        mask_load = 1'b0;
        check("R9 err high bits", int'(mask_err), 1);
        check("R9 kept2", int'(emit_en), 3);
        mask_in = 4'b0010; mask_load = 1'b1;
        @(negedge clk);
        mask_load = 1'b0;
        check("R9 accepted", int'(emit_en), 2);
        check("R9 no err", int'(mask_err), 0);
        seq[0] = 5; seq_n = 1;
        send_seq("R9 tx");
        check("R9 emitter0 dark", hc0, 0);
        check("R9 emitter1 lit", hc1, 15);
        mask_in = 4'b0011; mask_load = 1'b1;
        @(negedge clk);
        mask_load = 1'b0;
    endtask

    task automatic t_restart();
        begin_tx();
        push(40, 1'b0);
        push(40, 1'b0);
        repeat (10) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        push(40, 1'b1);
        wait_done("R11 restart");
        check("R11 mark0", highs[0], 120);
        check("R11 space", lows[0], 120);
        check("R11 mark1", highs[1], 120);
        check("R11 irqs", irqs, 3);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; cfg_load = 1'b0; mask_load = 1'b0;
        smp_valid = 1'b0; smp_last = 1'b0; smp_dur = '0;
        cfg_period = '0; cfg_duty = '0; mask_in = '0;
        clr_rec();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_default_carrier();
        t_basic();
        t_split();
        t_space_split();
        t_preload();
        t_carrier();
        t_mask();
        t_restart();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule